// File: doc/BRIEF.md
# Idle clock throttle controller

This block produces the clock enable for a small processor core that has two low-power states. In full-speed run mode the core is enabled on every system clock. In the throttled idle state the peripherals keep running on the system clock, but the core advances only once every 256 system clocks. In the stop state the core enable is held low until a hardware reset. The block also reports a registered "safe to sleep" flag. Firmware polls this flag before it enters a low-power state, so that it does not sleep while a peripheral transfer is under way.

Firmware selects a state through a small power-control register. The idle state is left automatically. An interrupt that the slow core takes on one of its throttled ticks always ends it. When the switchback option is enabled, the block also returns to full speed on the very next clock after an interrupt from a selected peripheral or a serial receive event. The idle request bit clears itself when the idle state ends. The clock-tree gating cell that consumes the enable sits outside this block.

Top module: `clk_throttle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to run mode with switchback disabled. After that edge `core_ce` is 1, `ctl_rdata` is 3'b000 and `sleep_safe` is 0.
- R2: The power-control register has three bits: bit 0 requests throttled idle, bit 1 requests stop, and bit 2 enables switchback. A write is taken only at an edge where `ctl_wr` and `core_ce` are both high. A write while `core_ce` is low changes nothing. `ctl_rdata` returns {switchback, in-stop, in-idle} in those same bit positions.
- R3: In run mode `core_ce` is high on every cycle.
- R4: A write with bit 0 set and bit 1 clear enters throttled idle and clears the divider. `core_ce` is then low for the 255 cycles after the entering edge and high on the 256th. After that it is high on exactly one cycle in every 256.
- R5: A write with bit 1 set enters stop, taking priority over bit 0. In stop, `core_ce` stays low, and interrupts, receive events and writes have no effect. Only `rst` leaves stop.
- R6: With switchback disabled, receive events do not end idle. Idle ends only at an edge where some `irq_req` bit is high while `core_ce` is high.
- R7: With switchback enabled, idle ends at the first edge where an `irq_req` bit selected by `WAKE_MASK` (default 4'b0101) is high, or where `rx_edge` is high. Unselected sources still follow R6.
- R8: When idle ends, the idle bit of `ctl_rdata` reads 0 and `core_ce` is high from the cycle after the ending edge.
- R9: `sleep_safe` is a register. After each edge it is 0 if any `periph_busy` bit was high before that edge, and 1 otherwise.
- R10: A write taken during idle updates switchback. If bit 1 is clear, bit 0 set restarts the 256-cycle period (the next enable comes 256 cycles later), and bit 0 clear returns to run mode. A wake event in the same cycle takes priority over the idle re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Power-control register write strobe |
| ctl_wdata | input | 3 | Write data: bit 0 idle, bit 1 stop, bit 2 switchback |
| irq_req | input | NIRQ | Pending enabled interrupt requests |
| rx_edge | input | 1 | One-cycle pulse when a serial receive bit is seen |
| periph_busy | input | NBUSY | High while a peripheral has a transfer in progress |
| core_ce | output | 1 | Core clock enable |
| ctl_rdata | output | 3 | Register read-back: bit 0 in idle, bit 1 in stop, bit 2 switchback |
| sleep_safe | output | 1 | Registered flag, 1 when no peripheral is busy |

## Verification
A wrong mode register shows on `ctl_rdata` and on `core_ce` in the cycle right after the faulty edge. A divider that is cleared late or counts wrongly only shows at the next throttled tick, up to 256 cycles later. That is why the reference model is compared on every cycle across whole throttle periods, and why tick spacing is also measured directly. Wake-logic faults show as an exit one cycle early or late, or at a missing or extra exit. Those are exposed by waking at chosen offsets from a tick.

// File: rtl/clk_throttle_pkg.sv
package clk_throttle_pkg;

    localparam int CTL_W    = 3;
    localparam int BIT_SLOW = 0;
    localparam int BIT_HALT = 1;
    localparam int BIT_SWB  = 2;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_SLOW = 2'd1,
        PM_HALT = 2'd2
    } pm_mode_e;

    typedef struct packed {
        logic swb;
        logic halt;
        logic slow;
    } pm_ctl_t;

    function automatic pm_ctl_t unpack_ctl(input logic [CTL_W-1:0] w);
        pm_ctl_t c;
        c.slow = w[BIT_SLOW];
        c.halt = w[BIT_HALT];
        c.swb  = w[BIT_SWB];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] status_word(input pm_mode_e m, input logic swb);
        logic [CTL_W-1:0] s;
        s = '0;
        s[BIT_SLOW] = (m == PM_SLOW);
        s[BIT_HALT] = (m == PM_HALT);
        s[BIT_SWB]  = swb;
        return s;
    endfunction

endpackage

// File: rtl/throttle_div.sv
module throttle_div #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    output logic tick
);
    localparam logic [DIV_LOG2-1:0] LAST = '1;

    logic [DIV_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = active && (cnt == LAST);

endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int              NIRQ      = 4,
    parameter logic [NIRQ-1:0] WAKE_MASK = 4'b0101
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic            rx_edge,
    input  logic            swb,
    input  logic            tick,
    output logic            wake
);
    logic [NIRQ-1:0] sel;

    for (genvar g = 0; g < NIRQ; g++) begin : g_src
        if (WAKE_MASK[g]) begin : g_on
            assign sel[g] = irq_req[g];
        end else begin : g_off
            assign sel[g] = 1'b0;
        end
    end

    logic slow_take;
    logic fast_take;

    assign slow_take = (|irq_req) && tick;
    assign fast_take = swb && ((|sel) || rx_edge);
    assign wake      = slow_take || fast_take;

endmodule

// File: rtl/busy_monitor.sv
module busy_monitor #(
    parameter int NBUSY = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBUSY-1:0] busy,
    output logic             safe
);
    logic any_busy;

    if (NBUSY == 1) begin : g_single
        assign any_busy = busy[0];
    end else begin : g_multi
        assign any_busy = |busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            safe <= 1'b0;
        end else begin
            safe <= !any_busy;
        end
    end

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import clk_throttle_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_ok,
    input  pm_ctl_t  wreq,
    input  logic     wake,
    output pm_mode_e mode,
    output logic     swb,
    output logic     restart
);
    pm_mode_e mode_n;
    logic     swb_n;

    always_comb begin
        mode_n  = mode;
        restart = 1'b0;
        swb_n   = wr_ok ? wreq.swb : swb;
        unique case (mode)
            PM_RUN: begin
                if (wr_ok) begin
                    if (wreq.halt) begin
                        mode_n = PM_HALT;
                    end else if (wreq.slow) begin
                        mode_n  = PM_SLOW;
                        restart = 1'b1;
                    end
                end
            end
            PM_SLOW: begin
                if (wr_ok && wreq.halt) begin
                    mode_n = PM_HALT;
                end else if (wake) begin
                    mode_n = PM_RUN;
                end else if (wr_ok && wreq.slow) begin
                    restart = 1'b1;
                end else if (wr_ok) begin
                    mode_n = PM_RUN;
                end
            end
            default: begin
                mode_n = PM_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= PM_RUN;
            swb  <= 1'b0;
        end else begin
            mode <= mode_n;
            swb  <= swb_n;
        end
    end

endmodule

// File: rtl/clk_throttle_ctrl.sv
module clk_throttle_ctrl
    import clk_throttle_pkg::*;
#(
    parameter int              NIRQ      = 4,
    parameter logic [NIRQ-1:0] WAKE_MASK = 4'b0101,
    parameter int              NBUSY     = 3,
    parameter int              DIV_LOG2  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [NIRQ-1:0]  irq_req,
    input  logic             rx_edge,
    input  logic [NBUSY-1:0] periph_busy,
    output logic             core_ce,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             sleep_safe
);
    pm_mode_e mode;
    pm_ctl_t  wreq;
    logic     swb;
    logic     restart;
    logic     tick;
    logic     wake;
    logic     wr_ok;
    logic     slow_active;

    assign wreq        = unpack_ctl(ctl_wdata);
    assign slow_active = (mode == PM_SLOW);
    assign core_ce     = (mode == PM_RUN) || (slow_active && tick);
    assign wr_ok       = ctl_wr && core_ce;

    pm_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (wr_ok),
        .wreq    (wreq),
        .wake    (wake),
        .mode    (mode),
        .swb     (swb),
        .restart (restart)
    );

    throttle_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk     (clk),
        .rst     (rst),
        .active  (slow_active),
        .restart (restart),
        .tick    (tick)
    );

    wake_detect #(.NIRQ(NIRQ), .WAKE_MASK(WAKE_MASK)) u_wake (
        .irq_req (irq_req),
        .rx_edge (rx_edge),
        .swb     (swb),
        .tick    (tick),
        .wake    (wake)
    );

    busy_monitor #(.NBUSY(NBUSY)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .busy (periph_busy),
        .safe (sleep_safe)
    );

    assign ctl_rdata = status_word(mode, swb);

endmodule

// File: rtl/clk_throttle_ctrl_chk.sv
module clk_throttle_ctrl_chk #(
    parameter int NBUSY    = 3,
    parameter int DIV_LOG2 = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic             wr_halt,
    input logic             rx_edge,
    input logic [NBUSY-1:0] periph_busy,
    input logic             core_ce,
    input logic [2:0]       ctl_rdata,
    input logic             sleep_safe
);
    localparam int DIV = 1 << DIV_LOG2;

    logic [DIV_LOG2:0] gap;

    always_ff @(posedge clk) begin
        if (rst || core_ce || !ctl_rdata[0]) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (core_ce && ctl_rdata == 3'b000));

    // R3
    run_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[1:0] == 2'b00) |-> core_ce);

    // R4
    slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] |-> (int'(gap) < DIV));

    // R4
    slow_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[0] && int'(gap) == DIV - 1) |-> core_ce);

    // R4
    slow_single_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[0] && core_ce) |=> (!core_ce || ctl_rdata[1:0] == 2'b00));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[1] |=> (ctl_rdata[1] && !core_ce));

    // R5
    halt_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[1] |-> !core_ce);

    // R7
    rx_switchback_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata == 3'b101 && rx_edge && !(ctl_wr && core_ce && wr_halt))
        |=> (ctl_rdata[1:0] == 2'b00));

    // R9
    busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|periph_busy) |=> !sleep_safe);

    // R9
    quiet_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_busy == '0) |=> sleep_safe);

endmodule

bind clk_throttle_ctrl clk_throttle_ctrl_chk #(
    .NBUSY    (NBUSY),
    .DIV_LOG2 (DIV_LOG2)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .wr_halt     (ctl_wdata[1]),
    .rx_edge     (rx_edge),
    .periph_busy (periph_busy),
    .core_ce     (core_ce),
    .ctl_rdata   (ctl_rdata),
    .sleep_safe  (sleep_safe)
);

// File: tb/clk_throttle_ctrl_tb.sv
module clk_throttle_ctrl_tb;
    localparam int         NIRQ  = 4;
    localparam logic [3:0] MASK  = 4'b0101;
    localparam int         NBUSY = 3;
    localparam int         DIVL  = 8;
    localparam int         DIV   = 1 << DIVL;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctl_wr = 1'b0;
    logic [2:0]       ctl_wdata = 3'b000;
    logic [NIRQ-1:0]  irq_req = '0;
    logic             rx_edge = 1'b0;
    logic [NBUSY-1:0] periph_busy = '0;
    logic             core_ce;
    logic [2:0]       ctl_rdata;
    logic             sleep_safe;

    always #10 clk = ~clk;

    clk_throttle_ctrl #(
        .NIRQ(NIRQ), .WAKE_MASK(MASK), .NBUSY(NBUSY), .DIV_LOG2(DIVL)
    ) u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .irq_req(irq_req), .rx_edge(rx_edge), .periph_busy(periph_busy),
        .core_ce(core_ce), .ctl_rdata(ctl_rdata), .sleep_safe(sleep_safe)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference model: 0 run, 1 idle, 2 stop
    int m_mode = 0;
    int m_cnt  = 0;
    bit m_swb  = 1'b0;
    bit m_safe = 1'b0;

    function automatic bit m_ce();
        return (m_mode == 0) || (m_mode == 1 && m_cnt == DIV - 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit ce, wk, wok;
        ce  = m_ce();
        wok = ctl_wr && ce;
        wk  = (m_mode == 1) && (((irq_req != 0) && ce) ||
              (m_swb && (((irq_req & MASK) != 0) || rx_edge)));
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_swb = 1'b0; m_safe = 1'b0;
        end else begin
            m_safe = (periph_busy == 0);
            if (m_mode == 1) m_cnt = (m_cnt + 1) % DIV;
            if (wok) m_swb = ctl_wdata[2];
            case (m_mode)
                0: if (wok) begin
                       if (ctl_wdata[1]) m_mode = 2;
                       else if (ctl_wdata[0]) begin m_mode = 1; m_cnt = 0; end
                   end
                1: begin
                       if (wok && ctl_wdata[1]) m_mode = 2;
                       else if (wk) m_mode = 0;
                       else if (wok && ctl_wdata[0]) m_cnt = 0;
                       else if (wok) m_mode = 0;
                   end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        string tg;
        if (m_mode == 0) tg = "R3 run enable";
        else if (m_mode == 1) tg = "R4 throttled enable";
        else tg = "R5 stop enable";
        chk(tg, int'(core_ce), int'(m_ce()));
        chk("R2 status read-back", int'(ctl_rdata),
            int'({m_swb, m_mode == 2, m_mode == 1}));
        chk("R9 sleep_safe", int'(sleep_safe), int'(m_safe));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [2:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        cyc();
        ctl_wr = 1'b0; ctl_wdata = 3'b000;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        int ticks;
        repeat (3) cyc();
        // R1 reset state
        chk("R1 reset core_ce", int'(core_ce), 1);
        chk("R1 reset status", int'(ctl_rdata), 0);
        chk("R1 reset sleep_safe", int'(sleep_safe), 0);
        rst = 1'b0;
        cyc();
        chk("R9 idle peripherals", int'(sleep_safe), 1);

        // R9 busy patterns
        periph_busy = 3'b010; cyc();
        chk("R9 busy clears flag", int'(sleep_safe), 0);
        periph_busy = 3'b101; cyc();
        chk("R9 multiple busy", int'(sleep_safe), 0);
        periph_busy = 3'b000; cyc();
        chk("R9 flag returns", int'(sleep_safe), 1);

        // R2 switchback-only write stays in run
        wr(3'b100);
        chk("R2 switchback bit", int'(ctl_rdata), 4);
        chk("R3 still full speed", int'(core_ce), 1);
        wr(3'b000);

        // R4 entry timing, R6 rx ignored without switchback
        ctl_wr = 1'b1; ctl_wdata = 3'b001;
        n = 0;
        do begin
            cyc(); n++;
            ctl_wr = 1'b0; ctl_wdata = 3'b000;
        end while (!core_ce && n < 1000);
        chk("R4 first tick after entry", n, 256);
        ticks = 0;
        for (int i = 0; i < 500; i++) begin
            rx_edge = (i % 50 == 7);
            periph_busy = (i % 64 < 5) ? 3'b001 : 3'b000;
            cyc();
            if (core_ce) ticks++;
        end
        rx_edge = 1'b0; periph_busy = '0;
        chk("R4 one tick per 256", ticks, 1);
        chk("R6 rx ignored", int'(ctl_rdata), 1);
        irq_req = 4'b0010;
        n = 0;
        do begin cyc(); n++; end while (ctl_rdata[0] && n < 1000);
        chk("R6 exit waits for tick", n, 13);
        chk("R8 full speed after exit", int'(core_ce), 1);
        chk("R8 idle bit cleared", int'(ctl_rdata), 0);
        irq_req = '0;
        cyc();

        // R2 write ignored while core enable is low
        wr(3'b001);
        repeat (10) cyc();
        wr(3'b010);
        chk("R2 write ignored when disabled", int'(ctl_rdata), 1);
        chk("R2 core still throttled", int'(core_ce), 0);

        // R10 re-entry at a tick restarts the period
        n = 0;
        while (!core_ce && n < 1000) begin cyc(); n++; end
        ctl_wr = 1'b1; ctl_wdata = 3'b001;
        n = 0;
        do begin
            cyc(); n++;
            ctl_wr = 1'b0; ctl_wdata = 3'b000;
        end while (!core_ce && n < 1000);
        chk("R10 restart period", n, 256);
        wr(3'b000);
        chk("R10 write leaves idle", int'(ctl_rdata), 0);
        chk("R10 full speed", int'(core_ce), 1);

        // R7 switchback on receive event
        wr(3'b101);
        repeat (30) cyc();
        rx_edge = 1'b1; cyc(); rx_edge = 1'b0;
        chk("R7 rx switchback", int'(ctl_rdata), 4);
        chk("R8 enable after switchback", int'(core_ce), 1);

        // R7 unselected source waits, selected source switches back
        wr(3'b101);
        repeat (20) cyc();
        irq_req = 4'b0010;
        repeat (5) cyc();
        chk("R7 unselected source waits", int'(ctl_rdata), 5);
        irq_req = 4'b0011; cyc();
        chk("R7 selected source", int'(ctl_rdata), 4);
        irq_req = '0;
        cyc();

        // R5 stop ignores everything but reset
        wr(3'b110);
        chk("R5 stop entered", int'(ctl_rdata), 6);
        for (int i = 0; i < 300; i++) begin
            irq_req = (i % 7 == 0) ? 4'b1111 : 4'b0000;
            rx_edge = (i % 11 == 0);
            ctl_wr  = (i % 13 == 0);
            ctl_wdata = 3'b001;
            cyc();
        end
        irq_req = '0; rx_edge = 1'b0; ctl_wr = 1'b0; ctl_wdata = 3'b000;
        chk("R5 stop held", int'(ctl_rdata), 6);
        chk("R5 enable low", int'(core_ce), 0);
        rst = 1'b1;
        cyc(); cyc();
        chk("R1 reset leaves stop", int'(ctl_rdata), 0);
        chk("R1 reset enable", int'(core_ce), 1);
        rst = 1'b0;
        cyc();
        finish_run();
    end

endmodule